// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block is the control for equality branches in a five-stage in-order pipeline. The branch is resolved in the decode stage rather than later in the pipe. The block owns the fetch address register. Each cycle it chooses the next fetch address. By default that is the sequential address, so the not-taken path is fetched with no delay. On a taken branch it loads the branch target instead, and it raises a squash request. That request turns the one instruction already fetched behind the branch into a no-op.

The two compared operands may still be in flight in older instructions. For each operand the block picks the freshest copy from three sources: the register file read, the execute/memory result, or the memory/writeback value. When no copy is ready yet, it holds decode and requests a bubble. A result that is still in execute gives a one-cycle hold. A load result gives a hold until its data reaches writeback. For a load directly ahead of the branch, that is two cycles.

Top module: `dec_branch_ctl`

## Requirements
- R1: During and right after reset, `fetch_pc` equals the RESET_PC parameter (default 0), and `stall` and `if_flush` are low.
- R2: When no branch is in decode, or a branch is in decode and its operands differ, `next_pc` is `fetch_pc + 4`, `if_flush` is low, and a hazard never raises `stall` unless `id_is_branch` is high.
- R3: The branch target is `id_pc + 4 + (sign-extended id_offset) * 4`. For example, a branch at 40 with offset 7 targets 72, and a branch at 100 with offset -3 targets 92.
- R4: A branch with equal operands and no stall drives `next_pc` to the target and raises `if_flush` for that cycle. `fetch_pc` holds the target after the following clock edge.
- R5: If the instruction in ID/EX writes a nonzero register that the branch compares, `stall` is high, `next_pc` equals `fetch_pc`, and `fetch_pc` holds across the edge.
- R6: If a load writing a compared register sits in ID/EX or in EX/MEM, `stall` is high. A load directly ahead of the branch therefore holds it for two cycles, and a load two ahead holds it for one.
- R7: If the EX/MEM instruction is not a load and writes a nonzero compared register, that operand's select is 1, and the comparison uses `exmem_result`.
- R8: If only MEM/WB writes a nonzero compared register, that operand's select is 2, and the comparison uses `memwb_wdata`. With no match, the select is 0 and the register file value is used.
- R9: When EX/MEM and MEM/WB both write the same compared register, EX/MEM wins (select 1).
- R10: Register 0 as a destination never causes a stall or a forward.
- R11: A stage whose register-write flag is low causes no stall and no forward.
- R12: While `stall` is high, `if_flush` stays low and the PC does not take the target, even when the operands compare equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_is_branch | input | 1 | An equality branch is in decode |
| id_pc | input | XLEN | Address of the branch in decode |
| id_offset | input | OFF_W | Signed word offset field of the branch |
| id_rs | input | RW | First compared register number |
| id_rt | input | RW | Second compared register number |
| rf_rs_val | input | XLEN | Register file value for id_rs |
| rf_rt_val | input | XLEN | Register file value for id_rt |
| idex_rd | input | RW | Destination of the instruction in ID/EX |
| idex_regwrite | input | 1 | ID/EX instruction writes a register |
| idex_memread | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | RW | Destination of the instruction in EX/MEM |
| exmem_regwrite | input | 1 | EX/MEM instruction writes a register |
| exmem_memread | input | 1 | EX/MEM instruction is a load |
| exmem_result | input | XLEN | ALU result held in EX/MEM |
| memwb_rd | input | RW | Destination of the instruction in MEM/WB |
| memwb_regwrite | input | 1 | MEM/WB instruction writes a register |
| memwb_wdata | input | XLEN | Value MEM/WB will write back |
| fetch_pc | output | XLEN | Current fetch address |
| next_pc | output | XLEN | Fetch address for the next cycle |
| if_flush | output | 1 | Squash the IF/ID register (taken branch) |
| stall | output | 1 | Hold PC and IF/ID, zero ID/EX control bits |
| fwd_a | output | 2 | Source select for id_rs: 0 file, 1 EX/MEM, 2 MEM/WB |
| fwd_b | output | 2 | Source select for id_rt: 0 file, 1 EX/MEM, 2 MEM/WB |

## Verification
The assertions take the stage fields to describe real, older instructions in program order. They assume that `*_memread` is set only together with `*_regwrite`, and that the register file values belong to the registers named this cycle. The stimulus builds each cycle as a snapshot of a real sequence: ALU-then-branch, load-then-branch, and load, ALU, then branch. Each load moves from ID/EX to EX/MEM to MEM/WB on successive cycles, so every hold the bench sees matches a producer the pipeline could actually contain.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
   typedef enum logic [1:0] {
      SRC_FILE  = 2'd0,
      SRC_EXMEM = 2'd1,
      SRC_MEMWB = 2'd2
   } opnd_src_e;
endpackage

// File: rtl/dbr_fwd_pick.sv
module dbr_fwd_pick #(
   parameter int RW   = 5,
   parameter int XLEN = 32
) (
   input  logic [RW-1:0]   src_reg,
   input  logic [XLEN-1:0] file_val,
   input  logic [RW-1:0]   ex_rd,
   input  logic            ex_wr,
   input  logic            ex_ld,
   input  logic [XLEN-1:0] ex_val,
   input  logic [RW-1:0]   wb_rd,
   input  logic            wb_wr,
   input  logic [XLEN-1:0] wb_val,
   output logic [1:0]      sel,
   output logic [XLEN-1:0] val
);
   import dbr_pkg::*;
   logic ex_ok, wb_ok;
   opnd_src_e pick;

   // a load in EX/MEM has no data yet; the hazard unit holds decode instead
   assign ex_ok = ex_wr && !ex_ld && (ex_rd != '0) && (ex_rd == src_reg);
   assign wb_ok = wb_wr && (wb_rd != '0) && (wb_rd == src_reg);

   always_comb begin
      if (ex_ok) begin
         pick = SRC_EXMEM;
         val  = ex_val;
      end else if (wb_ok) begin
         pick = SRC_MEMWB;
         val  = wb_val;
      end else begin
         pick = SRC_FILE;
         val  = file_val;
      end
   end
   assign sel = pick;
endmodule

// File: rtl/dbr_hazard.sv
module dbr_hazard #(
   parameter int RW = 5
) (
   input  logic          en,
   input  logic [RW-1:0] src_reg,
   input  logic [RW-1:0] idex_rd,
   input  logic          idex_wr,
   input  logic [RW-1:0] ex_rd,
   input  logic          ex_wr,
   input  logic          ex_ld,
   output logic          hold
);
   logic near_hit, load_hit;
   // producer still in execute: its value appears in EX/MEM next cycle
   assign near_hit = idex_wr && (idex_rd == src_reg);
   // load in memory stage: data only exists once it reaches MEM/WB
   assign load_hit = ex_wr && ex_ld && (ex_rd == src_reg);
   assign hold     = en && (src_reg != '0) && (near_hit || load_hit);
endmodule

// File: rtl/dbr_resolve.sv
module dbr_resolve #(
   parameter int XLEN  = 32,
   parameter int OFF_W = 16
) (
   input  logic [XLEN-1:0]  br_pc,
   input  logic [OFF_W-1:0] br_off,
   input  logic [XLEN-1:0]  opnd_a,
   input  logic [XLEN-1:0]  opnd_b,
   output logic             same,
   output logic [XLEN-1:0]  target
);
   localparam int EXT_W = XLEN - OFF_W;
   logic [XLEN-1:0] off_ext;

   assign off_ext = {{EXT_W{br_off[OFF_W-1]}}, br_off};
   assign target  = br_pc + XLEN'(4) + (off_ext << 2);
   assign same    = (opnd_a == opnd_b);
endmodule

// File: rtl/dec_branch_ctl.sv
module dec_branch_ctl #(
   parameter int              RW       = 5,
   parameter int              XLEN     = 32,
   parameter int              OFF_W    = 16,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             id_is_branch,
   input  logic [XLEN-1:0]  id_pc,
   input  logic [OFF_W-1:0] id_offset,
   input  logic [RW-1:0]    id_rs,
   input  logic [RW-1:0]    id_rt,
   input  logic [XLEN-1:0]  rf_rs_val,
   input  logic [XLEN-1:0]  rf_rt_val,
   input  logic [RW-1:0]    idex_rd,
   input  logic             idex_regwrite,
   input  logic             idex_memread,
   input  logic [RW-1:0]    exmem_rd,
   input  logic             exmem_regwrite,
   input  logic             exmem_memread,
   input  logic [XLEN-1:0]  exmem_result,
   input  logic [RW-1:0]    memwb_rd,
   input  logic             memwb_regwrite,
   input  logic [XLEN-1:0]  memwb_wdata,
   output logic [XLEN-1:0]  fetch_pc,
   output logic [XLEN-1:0]  next_pc,
   output logic             if_flush,
   output logic             stall,
   output logic [1:0]       fwd_a,
   output logic [1:0]       fwd_b
);
   localparam int NOPS = 2;

   if (RW < 1) begin : g_bad_rw
      $error("RW must be at least 1");
   end
   if (XLEN < OFF_W + 2) begin : g_bad_xlen
      $error("XLEN must exceed OFF_W by at least 2");
   end
   if (OFF_W < 2) begin : g_bad_off
      $error("OFF_W must be at least 2");
   end

   logic [RW-1:0]   op_reg  [NOPS];
   logic [XLEN-1:0] op_file [NOPS];
   logic [XLEN-1:0] op_val  [NOPS];
   logic [1:0]      op_sel  [NOPS];
   logic [NOPS-1:0] op_hold;
   logic            equal, taken;
   logic [XLEN-1:0] br_target;
   logic            idex_ld_unused;

   assign op_reg[0]  = id_rs;
   assign op_reg[1]  = id_rt;
   assign op_file[0] = rf_rs_val;
   assign op_file[1] = rf_rt_val;
   // any ID/EX writer already stalls, load or not
   assign idex_ld_unused = idex_memread;

   for (genvar i = 0; i < NOPS; i++) begin : g_opnd
      dbr_fwd_pick #(.RW(RW), .XLEN(XLEN)) u_pick (
         .src_reg (op_reg[i]),
         .file_val(op_file[i]),
         .ex_rd   (exmem_rd),
         .ex_wr   (exmem_regwrite),
         .ex_ld   (exmem_memread),
         .ex_val  (exmem_result),
         .wb_rd   (memwb_rd),
         .wb_wr   (memwb_regwrite),
         .wb_val  (memwb_wdata),
         .sel     (op_sel[i]),
         .val     (op_val[i])
      );
      dbr_hazard #(.RW(RW)) u_haz (
         .en     (id_is_branch),
         .src_reg(op_reg[i]),
         .idex_rd(idex_rd),
         .idex_wr(idex_regwrite),
         .ex_rd  (exmem_rd),
         .ex_wr  (exmem_regwrite),
         .ex_ld  (exmem_memread),
         .hold   (op_hold[i])
      );
   end

   dbr_resolve #(.XLEN(XLEN), .OFF_W(OFF_W)) u_res (
      .br_pc (id_pc),
      .br_off(id_offset),
      .opnd_a(op_val[0]),
      .opnd_b(op_val[1]),
      .same  (equal),
      .target(br_target)
   );

   assign stall    = |op_hold;
   assign taken    = id_is_branch && !stall && equal;
   assign if_flush = taken;
   assign fwd_a    = op_sel[0];
   assign fwd_b    = op_sel[1];

   always_comb begin
      if (stall)      next_pc = fetch_pc;
      else if (taken) next_pc = br_target;
      else            next_pc = fetch_pc + XLEN'(4);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fetch_pc <= RESET_PC;
      else        fetch_pc <= next_pc;
   end
endmodule

// File: rtl/dec_branch_ctl_chk.sv
module dec_branch_ctl_chk #(
   parameter int RW   = 5,
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            id_is_branch,
   input logic [RW-1:0]   id_rs,
   input logic [RW-1:0]   idex_rd,
   input logic            idex_regwrite,
   input logic [RW-1:0]   exmem_rd,
   input logic            exmem_regwrite,
   input logic            exmem_memread,
   input logic [XLEN-1:0] fetch_pc,
   input logic [XLEN-1:0] next_pc,
   input logic            if_flush,
   input logic            stall,
   input logic [1:0]      fwd_a,
   input logic [1:0]      fwd_b
);
   a_r4_flush_loads_pc: assert property (@(posedge clk) disable iff (!rst_n)
      if_flush |=> fetch_pc == $past(next_pc));
   a_r5_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(fetch_pc));
   a_r12_no_flush_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !(stall && if_flush));
   a_r6_load_ahead_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (id_is_branch && id_rs != '0 && exmem_regwrite && exmem_memread && exmem_rd == id_rs)
      |-> stall);
   a_r5_alu_ahead_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (id_is_branch && id_rs != '0 && idex_regwrite && idex_rd == id_rs) |-> stall);
   a_r10_zero_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rs == '0) |-> fwd_a == 2'd0);
   a_r8_select_legal: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_a != 2'd3 && fwd_b != 2'd3);
   a_r2_no_branch_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !id_is_branch |-> !stall && !if_flush);
endmodule

bind dec_branch_ctl dec_branch_ctl_chk #(.RW(RW), .XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .id_is_branch(id_is_branch), .id_rs(id_rs),
   .idex_rd(idex_rd), .idex_regwrite(idex_regwrite),
   .exmem_rd(exmem_rd), .exmem_regwrite(exmem_regwrite), .exmem_memread(exmem_memread),
   .fetch_pc(fetch_pc), .next_pc(next_pc), .if_flush(if_flush), .stall(stall),
   .fwd_a(fwd_a), .fwd_b(fwd_b)
);

// File: tb/tb_dec_branch_ctl.sv
module tb_dec_branch_ctl;
   localparam int RW = 5, XLEN = 32, OFF_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic id_is_branch;
   logic [XLEN-1:0] id_pc;
   logic [OFF_W-1:0] id_offset;
   logic [RW-1:0] id_rs, id_rt, idex_rd, exmem_rd, memwb_rd;
   logic [XLEN-1:0] rf_rs_val, rf_rt_val, exmem_result, memwb_wdata;
   logic idex_regwrite, idex_memread, exmem_regwrite, exmem_memread, memwb_regwrite;
   logic [XLEN-1:0] fetch_pc, next_pc;
   logic if_flush, stall;
   logic [1:0] fwd_a, fwd_b;

   always #4 clk = ~clk;

   dec_branch_ctl #(.RW(RW), .XLEN(XLEN), .OFF_W(OFF_W)) dut (.*);

   typedef struct {
      logic [XLEN-1:0] pc, npc;
      logic st, fl;
      logic [1:0] fa, fb;
      string req;
   } exp_t;

   exp_t q[$];
   int checks = 0, fails = 0;
   logic [XLEN-1:0] model_pc = '0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic begin_cycle();
      @(negedge clk);
      id_is_branch = 0; id_pc = '0; id_offset = '0; id_rs = '0; id_rt = '0;
      rf_rs_val = '0; rf_rt_val = '0;
      idex_rd = '0; idex_regwrite = 0; idex_memread = 0;
      exmem_rd = '0; exmem_regwrite = 0; exmem_memread = 0; exmem_result = '0;
      memwb_rd = '0; memwb_regwrite = 0; memwb_wdata = '0;
   endtask

   // driver side: expected item for the cycle just set up
   task automatic expect_cycle(input bit st, input bit tk, input logic [1:0] fa,
                               input logic [1:0] fb, input logic [XLEN-1:0] tgt,
                               input string req);
      exp_t e;
      e.pc  = model_pc;
      e.npc = st ? model_pc : (tk ? tgt : model_pc + 4);
      e.st  = st; e.fl = tk; e.fa = fa; e.fb = fb; e.req = req;
      q.push_back(e);
      model_pc = e.npc;
   endtask

   // monitor side
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(fetch_pc == e.pc, e.req, "fetch_pc", fetch_pc, e.pc);
            chk(next_pc == e.npc, e.req, "next_pc", next_pc, e.npc);
            chk(stall == e.st, e.req, "stall", XLEN'(stall), XLEN'(e.st));
            chk(if_flush == e.fl, e.req, "if_flush", XLEN'(if_flush), XLEN'(e.fl));
            chk(fwd_a == e.fa, e.req, "fwd_a", XLEN'(fwd_a), XLEN'(e.fa));
            chk(fwd_b == e.fb, e.req, "fwd_b", XLEN'(fwd_b), XLEN'(e.fb));
         end
      end
   end

   initial begin
      #(8 * 5000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      begin_cycle();
      begin_cycle();
      begin_cycle();
      #2;
      chk(fetch_pc == '0, "R1", "reset fetch_pc", fetch_pc, '0);
      chk(!stall && !if_flush, "R1", "reset stall/flush", XLEN'({stall, if_flush}), '0);

      // R1: first cycle after reset, pc still at reset value
      begin_cycle(); rst_n = 1;
      expect_cycle(0, 0, 0, 0, '0, "R1");
      // R2: idle sequential fetch
      begin_cycle();
      expect_cycle(0, 0, 0, 0, '0, "R2");
      // R2: non-branch with matching ID/EX writer never stalls
      begin_cycle(); id_rs = 3; idex_rd = 3; idex_regwrite = 1;
      expect_cycle(0, 0, 0, 0, '0, "R2");
      // R2: branch not taken, operands differ
      begin_cycle(); id_is_branch = 1; id_pc = 32'd60; id_offset = 16'd5;
      id_rs = 1; id_rt = 2; rf_rs_val = 5; rf_rt_val = 6;
      expect_cycle(0, 0, 0, 0, '0, "R2");
      // R3 R4: taken at 40 offset 7 -> 72
      begin_cycle(); id_is_branch = 1; id_pc = 32'd40; id_offset = 16'd7;
      id_rs = 1; id_rt = 2; rf_rs_val = 9; rf_rt_val = 9;
      expect_cycle(0, 1, 0, 0, 32'd72, "R3");
      // R4: pc now at target
      begin_cycle();
      expect_cycle(0, 0, 0, 0, '0, "R4");
      // R3: negative offset, 100 + 4 - 12 = 92
      begin_cycle(); id_is_branch = 1; id_pc = 32'd100; id_offset = 16'hFFFD;
      id_rs = 4; id_rt = 5; rf_rs_val = 3; rf_rt_val = 3;
      expect_cycle(0, 1, 0, 0, 32'd92, "R3");

      // ALU then branch: R5 and R12 (equal operands while stalled)
      begin_cycle(); id_is_branch = 1; id_pc = 32'd200; id_offset = 16'd2;
      id_rs = 3; id_rt = 4; rf_rs_val = 11; rf_rt_val = 11;
      idex_rd = 3; idex_regwrite = 1;
      expect_cycle(1, 0, 0, 0, '0, "R5");
      // R7: producer now in EX/MEM, stale file value ignored
      begin_cycle(); id_is_branch = 1; id_pc = 32'd200; id_offset = 16'd2;
      id_rs = 3; id_rt = 4; rf_rs_val = 0; rf_rt_val = 11;
      exmem_rd = 3; exmem_regwrite = 1; exmem_result = 11;
      expect_cycle(0, 1, 1, 0, 32'd212, "R7");

      // load then branch: R6 two-cycle hold, then R8 forward
      begin_cycle(); id_is_branch = 1; id_pc = 32'd300; id_offset = 16'd0;
      id_rs = 5; id_rt = 6; rf_rs_val = 7; rf_rt_val = 7;
      idex_rd = 5; idex_regwrite = 1; idex_memread = 1;
      expect_cycle(1, 0, 0, 0, '0, "R6");
      begin_cycle(); id_is_branch = 1; id_pc = 32'd300; id_offset = 16'd0;
      id_rs = 5; id_rt = 6; rf_rs_val = 7; rf_rt_val = 7;
      exmem_rd = 5; exmem_regwrite = 1; exmem_memread = 1;
      expect_cycle(1, 0, 0, 0, '0, "R6");
      begin_cycle(); id_is_branch = 1; id_pc = 32'd300; id_offset = 16'd0;
      id_rs = 5; id_rt = 6; rf_rs_val = 1; rf_rt_val = 7;
      memwb_rd = 5; memwb_regwrite = 1; memwb_wdata = 7;
      expect_cycle(0, 1, 2, 0, 32'd304, "R8");

      // load, ALU, branch on the load result: R6 one-cycle hold
      begin_cycle(); id_is_branch = 1; id_pc = 32'd400; id_offset = 16'd1;
      id_rs = 10; id_rt = 9; rf_rs_val = 4; rf_rt_val = 0;
      idex_rd = 8; idex_regwrite = 1;
      exmem_rd = 9; exmem_regwrite = 1; exmem_memread = 1;
      expect_cycle(1, 0, 0, 0, '0, "R6");
      begin_cycle(); id_is_branch = 1; id_pc = 32'd400; id_offset = 16'd1;
      id_rs = 10; id_rt = 9; rf_rs_val = 4; rf_rt_val = 0;
      exmem_rd = 8; exmem_regwrite = 1; exmem_result = 55;
      memwb_rd = 9; memwb_regwrite = 1; memwb_wdata = 4;
      expect_cycle(0, 1, 0, 2, 32'd408, "R8");

      // R9: both later stages write r1, EX/MEM must win
      begin_cycle(); id_is_branch = 1; id_pc = 32'd500; id_offset = 16'd3;
      id_rs = 1; id_rt = 2; rf_rs_val = 0; rf_rt_val = 20;
      exmem_rd = 1; exmem_regwrite = 1; exmem_result = 20;
      memwb_rd = 1; memwb_regwrite = 1; memwb_wdata = 30;
      expect_cycle(0, 1, 1, 0, 32'd516, "R9");

      // R10: register 0 destinations everywhere
      begin_cycle(); id_is_branch = 1; id_pc = 32'd600; id_offset = 16'd0;
      id_rs = 0; id_rt = 2; rf_rs_val = 0; rf_rt_val = 0;
      idex_rd = 0; idex_regwrite = 1; idex_memread = 1;
      exmem_rd = 0; exmem_regwrite = 1; exmem_result = 5;
      memwb_rd = 0; memwb_regwrite = 1; memwb_wdata = 6;
      expect_cycle(0, 1, 0, 0, 32'd604, "R10");

      // R11: matching registers but no write flags
      begin_cycle(); id_is_branch = 1; id_pc = 32'd700; id_offset = 16'd0;
      id_rs = 1; id_rt = 2; rf_rs_val = 3; rf_rt_val = 3;
      idex_rd = 1; exmem_rd = 2; exmem_memread = 1; exmem_result = 99;
      memwb_rd = 1; memwb_wdata = 42;
      expect_cycle(0, 1, 0, 0, 32'd704, "R11");

      begin_cycle();
      expect_cycle(0, 0, 0, 0, '0, "R2");
      begin_cycle();
      begin_cycle();
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule